// File: doc/BRIEF.md
# Tagged Address-Event Source Arbiter

This block sits in front of an event fan-out engine and collects address-events from three producers: two sensor arrays and one host port. Each producer raises a four-phase request/acknowledge handshake. All three share one address bus. Each producer drives that bus through its own tri-state buffer. The block picks one pending producer and turns on that producer's buffer alone. It waits a configurable settle time and then samples the bus.

The sampled address is widened with a small chip-select tag that names the producer. Identical addresses from different producers therefore become distinct presynaptic base addresses. The tagged word leaves on a valid/ready stream. The word is held steady under back-pressure, and the block grants nothing new until the downstream engine has taken it. The arbiter does not care what kind of device sits on each input. Any producer that follows the handshake can be attached.

The two sensors share service in round-robin order. The host port is served only when neither sensor is waiting.

Top module: `evt_tag_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, `src_ack`, `buf_en` and `out_valid` are all zero.
- R2: At most one bit of `buf_en` is high at any time. A granted source has its buffer enabled for exactly SETTLE_CYC cycles (default 1) before its acknowledge rises, and the buffer is off again when the acknowledge rises.
- R3: The address is taken from `bus_addr` while the granted buffer is enabled. `out_addr` equals {tag, address}, where the tag sits in the top CS_W bits and is 0 for sensor 0, 1 for sensor 1 and 2 for the host (the source index).
- R4: The acknowledge of the granted source rises in the same cycle that `out_valid` rises. It stays high while that source keeps its request high. It falls on the cycle after the request is seen low.
- R5: When both sensors request in the same cycle, the one not served most recently by a sensor grant wins. The first such contest after reset goes to sensor 0.
- R6: The host (source 2) is granted only when no sensor request is pending at the decision cycle.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_addr` is stable. No buffer enable or new acknowledge appears until the word is accepted.
- R8: The same address presented by each of the three sources yields three different output words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 3 | Per-source request, bit 2 = host |
| bus_addr | input | 13 | Shared address bus behind the source buffers |
| src_ack | output | 3 | Per-source acknowledge |
| buf_en | output | 3 | Per-source bus buffer enable |
| out_valid | output | 1 | Tagged word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_addr | output | 15 | {tag, address} presynaptic base address |

## Verification
The assertions assume that every producer obeys the four-phase rule. A producer raises its request only while its acknowledge is low. It keeps the request up until it sees the acknowledge. It changes its address only when it is not granted. They also assume that the bus carries the enabled buffer's value within the settle time. The bench models the three buffers as a priority mux with an all-ones idle value, so an early or late sample gives a wrong word. Every producer task drops its request only after its acknowledge, and raises a new one only after the previous acknowledge has fallen.

// File: rtl/evt_arb_pkg.sv
package evt_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HOLD   = 2'd2
  } arb_st_e;
endpackage

// File: rtl/evt_rr_pick.sv
// Chooses the next source: sensors in rotation, host strictly last.
module evt_rr_pick #(
  parameter int NSENS = 2,
  localparam int NSRC = NSENS + 1,
  localparam int IW   = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            take,
  output logic            pick_vld,
  output logic [IW-1:0]   pick_idx
);
  logic [IW-1:0] last_q;

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int k = 1; k <= NSENS; k++) begin
      int c;
      c = (int'(last_q) + k) % NSENS;
      if (!pick_vld && req[c]) begin
        pick_vld = 1'b1;
        pick_idx = IW'(c);
      end
    end
    if (!pick_vld && req[NSENS]) begin
      pick_vld = 1'b1;
      pick_idx = IW'(NSENS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= IW'(NSENS - 1);
    else if (take && (int'(pick_idx) < NSENS)) last_q <= pick_idx;
  end
endmodule

// File: rtl/evt_hs_ctrl.sv
// Four-phase handshake sequencing and buffer enables.
module evt_hs_ctrl
  import evt_arb_pkg::*;
#(
  parameter int NSRC       = 3,
  parameter int SETTLE_CYC = 1,
  localparam int IW        = $clog2(NSRC),
  localparam int CNT_W     = $clog2(SETTLE_CYC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            pick_vld,
  input  logic [IW-1:0]   pick_idx,
  input  logic            out_busy,
  input  logic            out_ready,
  output logic            take,
  output logic            sample,
  output logic [IW-1:0]   gnt_idx,
  output logic [NSRC-1:0] buf_en,
  output logic [NSRC-1:0] src_ack
);
  arb_st_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic          ack_on_q;
  logic          req_g;
  logic          ack_done;
  logic          out_done;

  assign req_g    = src_req[gnt_idx];
  assign take     = (st_q == ST_IDLE) && pick_vld && !out_busy;
  assign sample   = (st_q == ST_SETTLE) && (cnt_q == CNT_W'(SETTLE_CYC - 1));
  assign ack_done = !ack_on_q || !req_g;
  assign out_done = !out_busy || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      ack_on_q <= 1'b0;
      gnt_idx  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (take) begin
          gnt_idx <= pick_idx;
          cnt_q   <= '0;
          st_q    <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (sample) begin
            ack_on_q <= 1'b1;
            st_q     <= ST_HOLD;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (ack_on_q && !req_g) ack_on_q <= 1'b0;
          if (ack_done && out_done) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign buf_en[i]  = (st_q == ST_SETTLE) && (gnt_idx == IW'(i));
    assign src_ack[i] = ack_on_q && (gnt_idx == IW'(i));
  end
endmodule

// File: rtl/evt_tagger.sv
// Latches the bus address, prepends the source tag, drives the stream.
module evt_tagger #(
  parameter int ADDR_W = 13,
  parameter int CS_W   = 2,
  parameter int IW     = 2,
  localparam int OW    = CS_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [IW-1:0]     gnt_idx,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [OW-1:0]     out_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (sample) begin
      out_valid <= 1'b1;
      out_addr  <= {CS_W'(gnt_idx), bus_addr};
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/evt_tag_arbiter.sv
module evt_tag_arbiter #(
  parameter int NSENS      = 2,
  parameter int ADDR_W     = 13,
  parameter int CS_W       = 2,
  parameter int SETTLE_CYC = 1,
  localparam int NSRC      = NSENS + 1,
  localparam int IW        = $clog2(NSRC),
  localparam int OW        = CS_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NSRC-1:0]   src_ack,
  output logic [NSRC-1:0]   buf_en,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OW-1:0]     out_addr
);
  logic          pick_vld;
  logic [IW-1:0] pick_idx;
  logic          take;
  logic          sample;
  logic [IW-1:0] gnt_idx;

  evt_rr_pick #(.NSENS(NSENS)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(src_req), .take(take),
    .pick_vld(pick_vld), .pick_idx(pick_idx)
  );

  evt_hs_ctrl #(.NSRC(NSRC), .SETTLE_CYC(SETTLE_CYC)) u_hs (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .pick_vld(pick_vld), .pick_idx(pick_idx),
    .out_busy(out_valid), .out_ready(out_ready),
    .take(take), .sample(sample), .gnt_idx(gnt_idx),
    .buf_en(buf_en), .src_ack(src_ack)
  );

  evt_tagger #(.ADDR_W(ADDR_W), .CS_W(CS_W), .IW(IW)) u_tag (
    .clk(clk), .rst_n(rst_n), .sample(sample), .gnt_idx(gnt_idx),
    .bus_addr(bus_addr), .out_ready(out_ready),
    .out_valid(out_valid), .out_addr(out_addr)
  );
endmodule

// File: rtl/evt_arb_chk.sv
module evt_arb_chk #(
  parameter int NSRC   = 3,
  parameter int ADDR_W = 13,
  parameter int CS_W   = 2,
  localparam int OW    = CS_W + ADDR_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] src_req,
  input logic [NSRC-1:0] src_ack,
  input logic [NSRC-1:0] buf_en,
  input logic            out_valid,
  input logic            out_ready,
  input logic [OW-1:0]   out_addr
);
  // R2
  buf_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(buf_en));

  // R4
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(src_ack));

  // R4
  ack_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|src_ack) |-> $rose(out_valid));

  for (genvar i = 0; i < NSRC; i++) begin : g_hold
    // R4
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ack[i] && src_req[i]) |=> src_ack[i]);
  end

  // R3
  tag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ($past(buf_en) == (NSRC'(1) << out_addr[ADDR_W +: CS_W])));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R7
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (buf_en == '0));
endmodule

bind evt_tag_arbiter evt_arb_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .CS_W(CS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_ack(src_ack),
  .buf_en(buf_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr)
);

// File: tb/tb_evt_tag_arbiter.sv
module tb_evt_tag_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_req = '0;
  logic [12:0] bus_addr;
  logic [2:0]  src_ack;
  logic [2:0]  buf_en;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [14:0] out_addr;
  logic [12:0] a0 = '0, a1 = '0, a2 = '0;

  int n_chk = 0;
  int n_bad = 0;
  int last_s = 1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // tri-state buffers modelled as a mux; idle bus reads all ones
  assign bus_addr = buf_en[0] ? a0 : buf_en[1] ? a1 : buf_en[2] ? a2 : 13'h1FFF;

  evt_tag_arbiter dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .src_ack(src_ack), .buf_en(buf_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_grant(output int idx, output int bcyc);
    idx = -1;
    bcyc = 0;
    for (int t = 0; t < 20 && idx < 0; t++) begin
      @(negedge clk);
      if ($countones(buf_en) > 1) check(0, "R2 onehot", 32'(buf_en), 0);
      if (|buf_en) bcyc++;
      for (int i = 0; i < 3; i++) if (src_ack[i]) idx = i;
    end
  endtask

  task automatic finish(input int idx);
    src_req[idx] = 1'b0;
    @(negedge clk);
    check(src_ack == 3'b000, "R4 ack fall", 32'(src_ack), 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid, "R7 accept", 32'(out_valid), 0);
    if (idx < 2) last_s = idx;
  endtask

  task automatic t_reset();
    check(src_ack == 0 && buf_en == 0 && !out_valid, "R1 reset",
          {src_ack, buf_en, out_valid}, 0);
  endtask

  task automatic t_single(input int src, input logic [12:0] adr);
    int idx, bc;
    if (src == 0) a0 = adr; else if (src == 1) a1 = adr; else a2 = adr;
    src_req[src] = 1'b1;
    wait_grant(idx, bc);
    check(idx == src, "R6 grant src", 32'(idx), 32'(src));
    check(bc == 1, "R2 settle cycles", 32'(bc), 1);
    check(buf_en == 0, "R2 buffer off at ack", 32'(buf_en), 0);
    check(out_valid && out_addr == {2'(src), adr}, "R3 tagged word",
          32'(out_addr), 32'({2'(src), adr}));
    finish(src);
  endtask

  task automatic t_backpressure();
    int idx, bc;
    logic [14:0] w;
    a1 = 13'h1234;
    src_req[1] = 1'b1;
    wait_grant(idx, bc);
    w = out_addr;
    check(w == {2'd1, 13'h1234}, "R3 sensor1 word", 32'(w), 32'({2'd1, 13'h1234}));
    a0 = 13'h0777;
    src_req[0] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(out_valid && out_addr == w, "R7 hold", 32'(out_addr), 32'(w));
      check(buf_en == 0 && src_ack == 3'b010, "R7 no new grant",
            {buf_en, src_ack}, 32'(3'b010));
    end
    check(src_ack[1], "R4 ack held", 32'(src_ack), 32'(3'b010));
    finish(1);
    wait_grant(idx, bc);
    check(idx == 0 && out_addr == {2'd0, 13'h0777}, "R7 pending served after accept",
          32'(out_addr), 32'({2'd0, 13'h0777}));
    finish(0);
  endtask

  task automatic t_rr();
    int idx, bc, exp;
    a0 = 13'h0011;
    a1 = 13'h0022;
    src_req[0] = 1'b1;
    src_req[1] = 1'b1;
    for (int r = 0; r < 4; r++) begin
      exp = (last_s == 0) ? 1 : 0;
      wait_grant(idx, bc);
      check(idx == exp, "R5 round robin", 32'(idx), 32'(exp));
      finish(idx);
      src_req[idx] = 1'b1;
    end
    src_req[0] = 1'b0;
    src_req[1] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_host();
    int idx, bc;
    a1 = 13'h0AAA;
    a2 = 13'h0555;
    src_req[1] = 1'b1;
    src_req[2] = 1'b1;
    wait_grant(idx, bc);
    check(idx == 1, "R6 host yields", 32'(idx), 1);
    finish(1);
    wait_grant(idx, bc);
    check(idx == 2 && out_addr == {2'd2, 13'h0555}, "R6 host served",
          32'(out_addr), 32'({2'd2, 13'h0555}));
    finish(2);
  endtask

  task automatic t_same_addr();
    logic [14:0] w [3];
    int idx, bc;
    a0 = 13'h00F0; a1 = 13'h00F0; a2 = 13'h00F0;
    for (int s = 0; s < 3; s++) begin
      src_req[s] = 1'b1;
      wait_grant(idx, bc);
      w[s] = out_addr;
      check(w[s] == {2'(s), 13'h00F0}, "R8 word", 32'(w[s]), 32'({2'(s), 13'h00F0}));
      finish(s);
    end
    check(w[0] != w[1] && w[1] != w[2] && w[0] != w[2], "R8 distinct",
          32'(w[2]), 32'(15'h40F0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rr();
    t_single(0, 13'h0ABC);
    t_single(1, 13'h1FFE);
    t_single(2, 13'h0001);
    t_backpressure();
    t_host();
    t_same_addr();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule